// File: doc/BRIEF.md
# Two-Level Radix Page Table Walker

This block turns a virtual address into its leaf page table entry. It walks a two-level radix tree held in memory, with 4 KB pages. A request carries the effective address and the access length in bytes. A side input carries the root pointer taken from the current process's table entry. The walker reads one top-level entry, checks that it points at a next-level table, reads the matching leaf entry and returns it. If any check fails, it returns a not-found result with the faulting address instead.

Both levels of the tree have a fixed width. The top level has 1024 entries, indexed by virtual page number bits [18:9]. The leaf level has 512 entries, indexed by page number bits [8:0]. Every pointer carries a small size field in its low bits, and the walker checks that field before it uses the pointer. Table words are stored in memory in the reverse byte order, so the walker swaps each word before decoding it.

An access can run past the end of its page. In that case the walker also walks the following page and returns both leaf entries. If the second walk fails, the reported fault address is the first byte of that next page. The walker handles one request at a time.

Top module: `pt_walker`

## Requirements
- R1: Out of reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0. `req_ready` falls when a request is accepted and rises again only after the response is taken. No memory read is requested while `req_ready` is 1.
- R2: The root pointer's size field (bits [4:0]) must equal 10. Otherwise the result is not-found and no memory read is made. The first read address is (root AND 0x00FFFFFFFFFFFF00) + 8 × EA[30:21].
- R3: Each 64-bit word returned by memory is byte-reversed (byte 0 swapped with byte 7, and so on) before any field in it is used. The returned PTE is the reversed word.
- R4: A top-level entry is a valid pointer only when bit 63 is 1, bit 62 is 0 and bits [4:0] equal 9. Any other entry gives not-found. The leaf read address is (entry AND 0x00FFFFFFFFFFFF00) + 8 × EA[20:12].
- R5: A leaf entry gives a found result only when bits 63 and 62 are both 1. In that case `rsp_pte` carries the whole reversed entry.
- R6: An all-zero entry at either level gives not-found. On any not-found result, `rsp_fault_addr` equals the request address and both PTE outputs read zero.
- R7: If EA[11:0] + `req_bytes` (1 to 8) exceeds 4096, the access crosses a page. The walker then also walks the next page and returns its leaf in `rsp_pte_next`. If that second walk fails, `rsp_fault_addr` is the next page's start address. When the access does not cross a page, `rsp_pte_next` is 0.
- R8: Each memory read address is 8-byte aligned and stays stable, with `mem_req_valid` held, until `mem_req_ready` is seen. Each level issues exactly one read.
- R9: A response stays valid and unchanged until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_ptr | input | 64 | Root table base with size field in bits [4:0], sampled when a request is accepted |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_ea | input | 64 | Effective address to translate |
| req_bytes | input | 4 | Access length in bytes, 1 to 8 |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Table word as stored, byte-reversed |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_found | output | 1 | 1 if a translation was found, 0 if not |
| rsp_pte | output | 64 | Leaf entry for the page holding the address |
| rsp_pte_next | output | 64 | Leaf entry for the following page on a crossing access |
| rsp_fault_addr | output | 64 | Address reported on not-found |

## Verification
A wrong walk state shows first on the memory port, because the walker reads from an address that does not match the tree. Each read address is compared with the expected one when its handshake is made, so a wrong index, mask or state order is caught at the first bad read. A wrong decode of an entry, or a wrong crossing decision, changes the found flag, the returned entries or the fault address. These are checked on the response handshake, at most a few cycles after the faulty read. A lost or reissued read appears as an unexpected or missing address in the memory-read check.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int TOP_BITS  = 10,
  parameter int LEAF_BITS = 9,
  parameter int PAGE_BITS = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] root_ptr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [63:0] req_ea,
  input  logic [3:0]  req_bytes,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [63:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_found,
  output logic [63:0] rsp_pte,
  output logic [63:0] rsp_pte_next,
  output logic [63:0] rsp_fault_addr
);
  localparam int VPN_W = 64 - PAGE_BITS;
  localparam int SZ_W = 5;
  localparam logic [63:0] BASE_MASK = 64'h00FF_FFFF_FFFF_FF00;

  typedef enum logic [2:0] {S_IDLE, S_TOP_REQ, S_TOP_WAIT, S_LEAF_REQ, S_LEAF_WAIT, S_RESP} st_t;
  st_t state;

  logic [63:0] ea_q, root_q, dir_q, pte_q, nxt_q, fault_q;
  logic        cross_q, second_q, found_q;

  logic [VPN_W-1:0]     pg;
  logic [TOP_BITS-1:0]  top_idx;
  logic [LEAF_BITS-1:0] leaf_idx;
  logic [63:0]          ent;
  logic                 dir_ok, leaf_ok, cross_in;
  logic [PAGE_BITS:0]   span;

  assign pg       = ea_q[63:PAGE_BITS] + VPN_W'(second_q);
  assign top_idx  = pg[LEAF_BITS +: TOP_BITS];
  assign leaf_idx = pg[LEAF_BITS-1:0];

  always_comb
    for (int b = 0; b < 8; b++)
      ent[8*b +: 8] = mem_rsp_data[8*(7-b) +: 8];

  assign dir_ok  = ent[63] & ~ent[62] & (ent[SZ_W-1:0] == SZ_W'(LEAF_BITS));
  assign leaf_ok = ent[63] & ent[62];

  assign span     = {1'b0, req_ea[PAGE_BITS-1:0]} + {{(PAGE_BITS-3){1'b0}}, req_bytes};
  assign cross_in = span > (PAGE_BITS+1)'(1 << PAGE_BITS);

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_TOP_REQ) || (state == S_LEAF_REQ);
  assign mem_req_addr  = (state == S_TOP_REQ) ? root_q + 64'({top_idx, 3'b000})
                                              : dir_q + 64'({leaf_idx, 3'b000});
  assign rsp_valid      = (state == S_RESP);
  assign rsp_found      = found_q;
  assign rsp_pte        = found_q ? pte_q : '0;
  assign rsp_pte_next   = found_q ? nxt_q : '0;
  assign rsp_fault_addr = fault_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ea_q     <= '0;
      root_q   <= '0;
      dir_q    <= '0;
      pte_q    <= '0;
      nxt_q    <= '0;
      fault_q  <= '0;
      cross_q  <= 1'b0;
      second_q <= 1'b0;
      found_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE:
          if (req_valid) begin
            ea_q     <= req_ea;
            root_q   <= root_ptr & BASE_MASK;
            cross_q  <= cross_in;
            second_q <= 1'b0;
            found_q  <= 1'b0;
            pte_q    <= '0;
            nxt_q    <= '0;
            fault_q  <= req_ea;
            state    <= (root_ptr[SZ_W-1:0] == SZ_W'(TOP_BITS)) ? S_TOP_REQ : S_RESP;
          end
        S_TOP_REQ:
          if (mem_req_ready) state <= S_TOP_WAIT;
        S_TOP_WAIT:
          if (mem_rsp_valid) begin
            if (dir_ok) begin
              dir_q <= ent & BASE_MASK;
              state <= S_LEAF_REQ;
            end else begin
              if (second_q) fault_q <= {pg, PAGE_BITS'(0)};
              state <= S_RESP;
            end
          end
        S_LEAF_REQ:
          if (mem_req_ready) state <= S_LEAF_WAIT;
        S_LEAF_WAIT:
          if (mem_rsp_valid) begin
            if (!leaf_ok) begin
              if (second_q) fault_q <= {pg, PAGE_BITS'(0)};
              state <= S_RESP;
            end else if (second_q) begin
              nxt_q   <= ent;
              found_q <= 1'b1;
              state   <= S_RESP;
            end else begin
              pte_q <= ent;
              if (cross_q) begin
                second_q <= 1'b1;
                state    <= S_TOP_REQ;
              end else begin
                found_q <= 1'b1;
                state   <= S_RESP;
              end
            end
          end
        S_RESP:
          if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_found,
  input logic [63:0] rsp_pte,
  input logic [63:0] rsp_pte_next,
  input logic [63:0] rsp_fault_addr
);
  AST_BUSY_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R1
  AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R8
  AST_READ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_found, rsp_pte, rsp_pte_next, rsp_fault_addr})); // R9
  AST_FOUND_IS_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_found |-> rsp_pte[63:62] == 2'b11); // R5
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, mem_req_ready, mem_rsp_valid, rsp_ready;
  logic [63:0] root_ptr, req_ea, mem_rsp_data;
  logic [3:0]  req_bytes;
  logic req_ready, mem_req_valid, rsp_valid, rsp_found;
  logic [63:0] mem_req_addr, rsp_pte, rsp_pte_next, rsp_fault_addr;

  pt_walker dut (.*);

  localparam logic [63:0] MSK = 64'h00FF_FFFF_FFFF_FF00;
  localparam logic [63:0] DIRP = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LEAFP = 64'hC000_0000_0000_0000;

  typedef struct packed { logic found; logic [63:0] pte, nxt, fault; } exp_t;
  exp_t sb[$];
  string tag_q[$];
  logic [63:0] addr_q[$];
  logic [63:0] mem [logic [63:0]];
  int checks = 0, failures = 0;

  function automatic logic [63:0] swap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

  function automatic void put(input logic [63:0] a, input logic [63:0] v);
    mem[a] = swap64(v);
  endfunction

  function automatic logic [63:0] get(input logic [63:0] a);
    return mem.exists(a) ? swap64(mem[a]) : 64'd0;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic model(input logic [63:0] root, input logic [63:0] ea, input int nb, output exp_t e);
    logic [51:0] pg;
    logic [63:0] a1, a2, e1, e2;
    int npg;
    e = '0;
    e.fault = ea;
    if (root[4:0] != 5'd10) return;
    npg = (int'(ea[11:0]) + nb > 4096) ? 2 : 1;
    for (int p = 0; p < npg; p++) begin
      pg = ea[63:12] + 52'(p);
      a1 = (root & MSK) + 64'(pg[18:9]) * 8;
      addr_q.push_back(a1);
      e1 = get(a1);
      if (!(e1[63] && !e1[62] && e1[4:0] == 5'd9)) begin
        if (p == 1) e.fault = {pg, 12'h000};
        return;
      end
      a2 = (e1 & MSK) + 64'(pg[8:0]) * 8;
      addr_q.push_back(a2);
      e2 = get(a2);
      if (!(e2[63] && e2[62])) begin
        if (p == 1) e.fault = {pg, 12'h000};
        return;
      end
      if (p == 0) e.pte = e2; else e.nxt = e2;
    end
    e.found = 1'b1;
  endtask

  task automatic send(input string tag, input logic [63:0] root, input logic [63:0] ea, input int nb);
    exp_t e;
    model(root, ea, nb, e);
    sb.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    root_ptr = root; req_ea = ea; req_bytes = 4'(nb); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  // memory responder
  initial begin
    int stall = 0;
    logic pend = 1'b0;
    logic [63:0] pa = '0, ea_exp;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem.exists(pa) ? mem[pa] : 64'd0;
        pend = 1'b0;
      end
      mem_req_ready = 1'b0;
      if (rst_n && mem_req_valid && !mem_rsp_valid) begin
        stall++;
        if (stall % 3 != 0) begin
          mem_req_ready = 1'b1;
          pend = 1'b1;
          pa = mem_req_addr;
          if (addr_q.size() == 0) chk(1'b0, "R2 unexpected memory read", pa, 64'd0);
          else begin
            ea_exp = addr_q.pop_front();
            chk(pa == ea_exp, "R2 R4 R8 read address", pa, ea_exp);
          end
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    int tgl = 0;
    logic held = 1'b0;
    exp_t e;
    string t;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (held) chk(rsp_valid, "R9 response dropped before accept", 64'(rsp_valid), 64'd1);
      rsp_ready = 1'b0;
      held = 1'b0;
      if (rst_n && rsp_valid) begin
        chk(!req_ready, "R1 req_ready high with response pending", 64'(req_ready), 64'd0);
        tgl++;
        if (tgl % 2 == 0) held = 1'b1;
        else begin
          rsp_ready = 1'b1;
          if (sb.size() == 0) chk(1'b0, "R1 unexpected response", 64'd1, 64'd0);
          else begin
            e = sb.pop_front();
            t = tag_q.pop_front();
            chk(rsp_found == e.found, {t, " found flag"}, 64'(rsp_found), 64'(e.found));
            if (e.found) begin
              chk(rsp_pte == e.pte, {t, " R3 leaf PTE"}, rsp_pte, e.pte);
              chk(rsp_pte_next == e.nxt, {t, " R7 next-page PTE"}, rsp_pte_next, e.nxt);
            end else begin
              chk(rsp_fault_addr == e.fault, {t, " fault address"}, rsp_fault_addr, e.fault);
              chk(rsp_pte == 0 && rsp_pte_next == 0, {t, " R6 PTE outputs zero on miss"}, rsp_pte | rsp_pte_next, 64'd0);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=%0d exp=%0d", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [63:0] ROOT = 64'h1_000A;

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_bytes = '0; root_ptr = '0;
    // tree: top entries at 0x10000
    put(64'h10000, DIRP | 64'h14000 | 9);
    put(64'h14000 + 64'h124 * 8, LEAFP | 64'h8000 | 64'h186);
    put(64'h10000 + 8 * 8, DIRP | 64'h15000 | 9);
    put(64'h15000 + 64'h124 * 8, LEAFP | 64'h8000 | 64'h186);
    put(64'h10000 + 3 * 8, LEAFP | 64'h16000 | 9);
    put(64'h10000 + 4 * 8, DIRP | 64'h16000 | 8);
    put(64'h16000, LEAFP | 64'hA000 | 64'h186);
    put(64'h14000 + 64'h130 * 8, DIRP | 64'h9000 | 64'h106);
    put(64'h10000 + 1 * 8, DIRP | 64'h17000 | 9);
    put(64'h17000 + 64'h19f * 8, LEAFP | 64'hB000 | 64'h186);
    put(64'h17000 + 64'h1ff * 8, LEAFP | 64'hD000 | 64'h104);
    put(64'h10000 + 5 * 8, 64'h8F00_0000_0001_80E9);
    put(64'h18000 + 7 * 8, LEAFP | 64'hE000 | 64'h105);
    put(64'h20000, DIRP | 64'h14000 | 9);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    send("R6 zero leaf", ROOT, 64'h123000, 8);
    send("R6 zero top entry", ROOT, 64'h40_0000, 8);
    send("R5 mapped read", ROOT, 64'h124108, 8);
    send("R2 second top index", ROOT, 64'h112_4108, 8);
    send("R4 top entry marked leaf", ROOT, 64'h60_0000, 8);
    send("R4 wrong size field", ROOT, 64'h80_0000, 8);
    send("R5 leaf bit clear", ROOT, 64'h130000, 4);
    send("R7 straddle unmapped", ROOT, 64'h39fffd, 8);
    send("R7 no crossing", ROOT, 64'h39fff8, 8);
    put(64'h17000 + 64'h1a0 * 8, LEAFP | 64'hC000 | 64'h181);
    send("R7 straddle mapped", ROOT, 64'h39fffd, 8);
    send("R7 straddle over top index", ROOT, 64'h3f_fffc, 8);
    send("R2 bad root size", 64'h1_0009, 64'h124000, 8);
    send("R2 masked root base", 64'h2_00EA, 64'h124000, 1);
    send("R4 masked directory base", ROOT, 64'hA0_7010, 2);
    repeat (5) @(negedge clk);
    chk(addr_q.size() == 0, "R8 missing memory reads", 64'(addr_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule